// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the mode-0 serial slave front end of a byte-addressed non-volatile memory. It watches the chip select, serial clock, serial data in and pause pins. It shifts in an 8-bit instruction, a 16-bit address and the data bytes, and it shifts read data or the status byte back out. The pins arrive already synchronised to the core clock `clk`. The block finds the serial clock edges by comparing each pin with its value on the previous core cycle. The serial output is given as a data bit plus an enable, and the pad ring builds the three-state driver from the two.

Two units sit beside it. A page-write sequencer receives one byte-load pulse per completed write byte, and a commit pulse when the write frame closes cleanly. A status unit receives pulses that set or clear the write-enable latch, a status-write pulse carrying the new byte, and supplies the status byte for reads. Array reads are combinational: the block presents `rd_addr` and samples `rd_data` when a byte starts to shift out.

The controller is one state machine. States: `ST_IDLE` (deselected), `ST_OPCODE`, `ST_ADDR_HI`, `ST_ADDR_LO`, `ST_READ`, `ST_WRITE`, `ST_SR_READ`, `ST_SR_WRITE`, `ST_CMD_DONE` and `ST_IGNORE`. Transitions:
- IDLE→OPCODE on select.
- OPCODE→ADDR_HI for the read and write opcodes.
- OPCODE→CMD_DONE for the set-latch and clear-latch opcodes.
- OPCODE→SR_READ for the status-read opcode.
- OPCODE→SR_WRITE for the status-write opcode.
- OPCODE→IGNORE for any other code.
- ADDR_HI→ADDR_LO after the first address byte.
- ADDR_LO→READ or ADDR_LO→WRITE after the second address byte.
- SR_WRITE→IGNORE after its data byte.
- CMD_DONE→IGNORE on any further serial clock rise.
- Any state→IDLE on deselect.

Top module: `spi_mem_slave`

## Requirements
- R1: Serial input bits are captured MSB first on serial clock rising edges. The opcodes are 0x06 set-latch, 0x04 clear-latch, 0x05 status-read, 0x01 status-write, 0x03 read and 0x02 write.
- R2: Read and status data leave MSB first. A new bit is driven at each serial clock falling edge, and the first bit is driven at the fall that follows the last address or opcode bit. `so_en` is high only in a read or status-read phase while selected and not paused.
- R3: While `cs_n` is high, `so_en` is low. A new select always starts with a fresh opcode and bit count.
- R4: The read address is the low ADDR_W bits of the 16 address bits, and the upper bits are ignored. The address increments after each byte read and wraps from all-ones to zero.
- R5: In a write, each completed data byte gives a one-cycle `byte_load_valid` with its address and data. The address then increments.
- R6: `commit` pulses once at deselect only if at least one write byte was loaded and no bit of a later byte was clocked in.
- R7: `wren_req` or `wrdi_req` pulses at deselect only after exactly eight opcode bits. Any additional serial clock rise cancels it.
- R8: During a status read, `sr_rd_data` is sent repeatedly, one byte after another.
- R9: A status write gives a one-cycle `sr_wr_valid` with the first data byte. Later bits have no effect.
- R10: An unknown opcode produces no request pulse and keeps `so_en` low until deselect.
- R11: A `hold_n` fall while `sck` is low pauses the transfer. Clock and data changes are then ignored and `so_en` is low. Raising `hold_n` while `sck` is low resumes the transfer from the same bit.
- R12: Request pulses are mutually exclusive in any cycle, and `byte_load_valid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low reset |
| cs_n | input | 1 | chip select, active low |
| sck | input | 1 | serial clock, mode 0 |
| si | input | 1 | serial data in |
| hold_n | input | 1 | pause request, active low |
| so | output | 1 | serial data out bit |
| so_en | output | 1 | serial output driver enable |
| rd_addr | output | ADDR_W | array read address |
| rd_data | input | 8 | array read data for rd_addr |
| byte_load_valid | output | 1 | write byte complete pulse |
| byte_load_addr | output | ADDR_W | address of the loaded byte |
| byte_load_data | output | 8 | loaded byte |
| commit | output | 1 | start page programming pulse |
| wren_req | output | 1 | set write-enable latch pulse |
| wrdi_req | output | 1 | clear write-enable latch pulse |
| sr_wr_valid | output | 1 | status write pulse |
| sr_wr_data | output | 8 | status write byte |
| sr_rd_data | input | 8 | current status byte |

## Verification
The bench sweeps read start addresses. The sweep includes all-ones with the ignored top bit set, where a design that kept that bit or failed to wrap would return data from the wrong location. Write frames of one to four bytes are closed cleanly and also mid-byte, to catch a commit that fires on a torn byte. A set-latch frame followed by stray clocks checks that the pulse is cancelled. A pause in the middle of a read byte, with the clock toggled during the pause, would expose a design that keeps counting bits or keeps driving the output: the resumed byte would come back shifted or `so_en` would stay high.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [7:0] {
        OP_WRSR  = 8'h01,
        OP_WRITE = 8'h02,
        OP_READ  = 8'h03,
        OP_WRDI  = 8'h04,
        OP_RDSR  = 8'h05,
        OP_WREN  = 8'h06
    } opcode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_READ,
        ST_WRITE,
        ST_SR_READ,
        ST_SR_WRITE,
        ST_CMD_DONE,
        ST_IGNORE
    } state_e;

endpackage

// File: rtl/spi_pin_sampler.sv
// Edge detection of the serial pins in the core clock domain, plus pause tracking.
module spi_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic held
);
    logic sck_q, cs_q, hold_q, active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            cs_q   <= 1'b1;
            hold_q <= 1'b1;
            held   <= 1'b0;
        end else begin
            sck_q  <= sck;
            cs_q   <= cs_n;
            hold_q <= hold_n;
            if (cs_n)
                held <= 1'b0;
            else if (!held && hold_q && !hold_n && !sck)
                held <= 1'b1;
            else if (held && hold_n && !sck)
                held <= 1'b0;
        end
    end

    assign active   = !cs_n && !held;
    assign sck_rise = active && sck && !sck_q;
    assign sck_fall = active && !sck && sck_q;
    assign cs_rise  = cs_n && !cs_q;
endmodule

// File: rtl/spi_tx_shifter.sv
// MSB-first output shifter, advanced on serial clock falls.
module spi_tx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         so_bit
);
    logic [W-1:0] out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            so_bit <= 1'b0;
        end else if (shift_en) begin
            if (load) begin
                so_bit <= load_val[W-1];
                out_q  <= {load_val[W-2:0], 1'b0};
            end else begin
                so_bit <= out_q[W-1];
                out_q  <= {out_q[W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              byte_load_valid,
    output logic [ADDR_W-1:0] byte_load_addr,
    output logic [7:0]        byte_load_data,
    output logic              commit,
    output logic              wren_req,
    output logic              wrdi_req,
    output logic              sr_wr_valid,
    output logic [7:0]        sr_wr_data,
    input  logic [7:0]        sr_rd_data
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int HI_W   = ADDR_W - BYTE_W;

    state_e             state, state_nx;
    logic               sck_rise, sck_fall, cs_rise, held;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-2:0]  shin_q;
    logic [BYTE_W-1:0]  rx_byte;
    logic               byte_done;
    logic [HI_W-1:0]    hi_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               is_write_q, is_wren_q, wr_ok_q;
    logic               drive_phase;

    spi_pin_sampler u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .hold_n   (hold_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise),
        .held     (held)
    );

    assign rx_byte     = {shin_q, si};
    assign byte_done   = sck_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign drive_phase = (state == ST_READ) || (state == ST_SR_READ);

    spi_tx_shifter #(.W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sck_fall && drive_phase),
        .load     (bit_cnt == '0),
        .load_val ((state == ST_SR_READ) ? sr_rd_data : rd_data),
        .so_bit   (so)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (cs_n) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_OPCODE;
                ST_OPCODE:   if (byte_done) begin
                                 case (rx_byte)
                                     OP_READ, OP_WRITE: state_nx = ST_ADDR_HI;
                                     OP_WREN, OP_WRDI:  state_nx = ST_CMD_DONE;
                                     OP_RDSR:           state_nx = ST_SR_READ;
                                     OP_WRSR:           state_nx = ST_SR_WRITE;
                                     default:           state_nx = ST_IGNORE;
                                 endcase
                             end
                ST_ADDR_HI:  if (byte_done) state_nx = ST_ADDR_LO;
                ST_ADDR_LO:  if (byte_done) state_nx = is_write_q ? ST_WRITE : ST_READ;
                ST_SR_WRITE: if (byte_done) state_nx = ST_IGNORE;
                ST_CMD_DONE: if (sck_rise)  state_nx = ST_IGNORE;
                ST_READ, ST_WRITE, ST_SR_READ, ST_IGNORE: state_nx = state;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt         <= '0;
            shin_q          <= '0;
            hi_q            <= '0;
            addr_q          <= '0;
            is_write_q      <= 1'b0;
            is_wren_q       <= 1'b0;
            wr_ok_q         <= 1'b0;
            byte_load_valid <= 1'b0;
            byte_load_addr  <= '0;
            byte_load_data  <= '0;
            commit          <= 1'b0;
            wren_req        <= 1'b0;
            wrdi_req        <= 1'b0;
            sr_wr_valid     <= 1'b0;
            sr_wr_data      <= '0;
        end else begin
            byte_load_valid <= 1'b0;
            sr_wr_valid     <= 1'b0;
            commit          <= cs_rise && (state == ST_WRITE) && wr_ok_q;
            wren_req        <= cs_rise && (state == ST_CMD_DONE) && is_wren_q;
            wrdi_req        <= cs_rise && (state == ST_CMD_DONE) && !is_wren_q;
            if (cs_n) begin
                bit_cnt <= '0;
                wr_ok_q <= 1'b0;
            end else if (sck_rise) begin
                bit_cnt <= bit_cnt + CNT_W'(1);
                shin_q  <= rx_byte[BYTE_W-2:0];
                if (state == ST_WRITE) wr_ok_q <= byte_done;
            end
            if (byte_done) begin
                unique case (state)
                    ST_OPCODE: begin
                        is_write_q <= (rx_byte == OP_WRITE);
                        is_wren_q  <= (rx_byte == OP_WREN);
                    end
                    ST_ADDR_HI: hi_q   <= rx_byte[HI_W-1:0];
                    ST_ADDR_LO: addr_q <= {hi_q, rx_byte};
                    ST_READ:    addr_q <= addr_q + ADDR_W'(1);
                    ST_WRITE: begin
                        byte_load_valid <= 1'b1;
                        byte_load_addr  <= addr_q;
                        byte_load_data  <= rx_byte;
                        addr_q          <= addr_q + ADDR_W'(1);
                    end
                    ST_SR_WRITE: begin
                        sr_wr_valid <= 1'b1;
                        sr_wr_data  <= rx_byte;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_addr = addr_q;
    assign so_en   = drive_phase && !cs_n && !held;
endmodule

// File: rtl/spi_mem_slave_checker.sv
module spi_mem_slave_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic hold_n,
    input logic so_en,
    input logic byte_load_valid,
    input logic commit,
    input logic wren_req,
    input logic wrdi_req,
    input logic sr_wr_valid
);
    assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !so_en);

    assert_commit_deselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> cs_n);

    assert_latch_req_deselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wren_req || wrdi_req) |-> cs_n);

    assert_pause_floats_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_n) && !sck && !cs_n) |=> !so_en);

    assert_req_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_load_valid, commit, wren_req, wrdi_req, sr_wr_valid}));

    assert_load_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        byte_load_valid |=> !byte_load_valid);

    assert_load_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_load_valid || sr_wr_valid) |-> $past(!cs_n));
endmodule

bind spi_mem_slave spi_mem_slave_checker u_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .cs_n            (cs_n),
    .sck             (sck),
    .hold_n          (hold_n),
    .so_en           (so_en),
    .byte_load_valid (byte_load_valid),
    .commit          (commit),
    .wren_req        (wren_req),
    .wrdi_req        (wrdi_req),
    .sr_wr_valid     (sr_wr_valid)
);

// File: tb/test_spi_mem_slave.sv
module test_spi_mem_slave;
    localparam int AW = 15;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_en, byte_load_valid, commit, wren_req, wrdi_req, sr_wr_valid;
    logic [AW-1:0] rd_addr, byte_load_addr;
    logic [7:0] rd_data, byte_load_data, sr_wr_data, sr_rd_data;

    int n_tests = 0, n_fail = 0;
    int bl_cnt = 0, commit_cnt = 0, wren_cnt = 0, wrdi_cnt = 0, srw_cnt = 0;
    logic [AW-1:0] bl_addr [0:15];
    logic [7:0]    bl_data [0:15];
    logic [7:0]    srw_last;

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_val(input logic [AW-1:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
    endfunction

    assign rd_data    = mem_val(rd_addr);
    assign sr_rd_data = 8'hA5;

    spi_mem_slave #(.ADDR_W(AW)) i_spi_mem_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .so(so), .so_en(so_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .byte_load_valid(byte_load_valid), .byte_load_addr(byte_load_addr),
        .byte_load_data(byte_load_data), .commit(commit), .wren_req(wren_req),
        .wrdi_req(wrdi_req), .sr_wr_valid(sr_wr_valid), .sr_wr_data(sr_wr_data),
        .sr_rd_data(sr_rd_data)
    );

    always @(posedge clk) begin
        if (byte_load_valid) begin
            if (bl_cnt < 16) begin
                bl_addr[bl_cnt] <= byte_load_addr;
                bl_data[bl_cnt] <= byte_load_data;
            end
            bl_cnt <= bl_cnt + 1;
        end
        if (commit)      commit_cnt <= commit_cnt + 1;
        if (wren_req)    wren_cnt   <= wren_cnt + 1;
        if (wrdi_req)    wrdi_cnt   <= wrdi_cnt + 1;
        if (sr_wr_valid) begin
            srw_cnt  <= srw_cnt + 1;
            srw_last <= sr_wr_data;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic select();
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic deselect();
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(4);
    endtask

    // one byte; bit index hold_bit (or -1) gets a pause inserted in its low phase
    task automatic xfer(input logic [7:0] tx, input int hold_bit, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            si = tx[i];
            wait_clk(4);
            if (i == hold_bit) begin
                hold_n = 1'b0;
                wait_clk(3);
                check("R11 paused so_en", so_en, 1'b0);
                for (int k = 0; k < 3; k++) begin
                    sck = 1'b1; si = ~si; wait_clk(2);
                    sck = 1'b0; wait_clk(2);
                end
                check("R11 paused after clocks", so_en, 1'b0);
                hold_n = 1'b1;
                wait_clk(3);
                si = tx[i];
                wait_clk(2);
            end
            rx[i] = so_en ? so : 1'bx;
            sck = 1'b1;
            wait_clk(4);
            sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] dummy;
        xfer(tx, -1, dummy);
    endtask

    initial begin
        logic [7:0] rx;
        logic [AW-1:0] a;
        int base;
        wait_clk(3);
        check("R3 reset so_en", so_en, 1'b0);
        check("R12 reset pulses", {byte_load_valid, commit, wren_req, wrdi_req, sr_wr_valid}, 5'b0);
        rst_n = 1'b1;
        wait_clk(3);

        // R4 R2 R1: read sweep over start addresses, 16-bit addresses with top bit ignored
        foreach (bl_data[j]) begin : sweep
            logic [15:0] starts [0:7];
            if (j >= 8) break;
            starts = '{16'h0000, 16'h0001, 16'h00FF, 16'h1234, 16'h7FFE, 16'hFFFE, 16'h8000, 16'hFFFF};
            select();
            send(8'h03);
            send(starts[j][15:8]);
            send(starts[j][7:0]);
            a = starts[j][AW-1:0];
            for (int b = 0; b < 3; b++) begin
                xfer(8'h00, -1, rx);
                check($sformatf("R4 R2 read start %h byte %0d", starts[j], b), rx, mem_val(a));
                a = a + AW'(1);
            end
            deselect();
            check("R3 so_en after deselect", so_en, 1'b0);
        end

        // R8: status read repeats
        select();
        send(8'h05);
        for (int b = 0; b < 3; b++) begin
            xfer(8'h00, -1, rx);
            check("R8 status byte", rx, 8'hA5);
        end
        deselect();

        // R7: set and clear latch
        select();
        send(8'h06);
        wait_clk(4);
        check("R7 wren not before deselect", wren_cnt, 0);
        deselect();
        check("R7 wren after deselect", wren_cnt, 1);
        select(); send(8'h04); deselect();
        check("R7 wrdi after deselect", wrdi_cnt, 1);
        check("R7 no wren from wrdi", wren_cnt, 1);
        select(); send(8'h06); send(8'h00); deselect();
        check("R7 extra clocks cancel", wren_cnt, 1);

        // R5 R6: write sweep, 1..4 bytes
        base = 0;
        for (int len = 1; len <= 4; len++) begin
            logic [15:0] wa;
            wa = 16'h80F0 + 16'(len * 3);
            select();
            send(8'h02); send(wa[15:8]); send(wa[7:0]);
            for (int b = 0; b < len; b++) send(8'(8'h40 + len * 16 + b));
            deselect();
            check("R5 byte count", bl_cnt, base + len);
            for (int b = 0; b < len; b++) begin
                check("R5 load addr", bl_addr[base + b], wa[AW-1:0] + AW'(b));
                check("R5 load data", bl_data[base + b], 8'(8'h40 + len * 16 + b));
            end
            check("R6 commit on clean close", commit_cnt, len);
            base = base + len;
        end

        // R6: torn byte gives no commit
        select();
        send(8'h02); send(8'h00); send(8'h10); send(8'h77);
        si = 1'b1; wait_clk(4); sck = 1'b1; wait_clk(4); sck = 1'b0;
        deselect();
        check("R6 torn byte no commit", commit_cnt, 4);
        check("R5 torn byte one load", bl_cnt, base + 1);

        // R1 R9: status write
        select(); send(8'h01); send(8'h8C); send(8'h13); deselect();
        check("R9 status write count", srw_cnt, 1);
        check("R9 status write data", srw_last, 8'h8C);

        // R10: unknown opcode
        select(); send(8'hAB); send(8'h03); send(8'h06);
        check("R10 so_en low", so_en, 1'b0);
        deselect();
        check("R10 no requests", wren_cnt + wrdi_cnt + srw_cnt + commit_cnt, 1 + 1 + 1 + 4);

        // R11: pause mid-byte during a read
        select();
        send(8'h03); send(8'h02); send(8'h5A);
        xfer(8'h00, 4, rx);
        check("R11 resumed byte", rx, mem_val(AW'(16'h025A)));
        xfer(8'h00, -1, rx);
        check("R11 following byte", rx, mem_val(AW'(16'h025B)));
        deselect();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule